// File: doc/BRIEF.md
# UART Channel Interrupt Priority Encoder

This block gathers the interrupt sources of a single UART channel and presents the most urgent pending one as a 3-bit code. The same code is what a status register read returns. Each source keeps its own pending state and has its own way of being cleared. Depending on the source, the clear comes from reading the status register, reading the line or modem status register, reading the timer control register, or a change in receive FIFO level. The FIFOs, the line logic and the modem logic sit outside the block and reach it as level and one-cycle event inputs.

The encoder reports the lowest nonzero pending code. A zero code means nothing is pending, and `irq_o` is high whenever any enabled source is pending. A status register read acts on the code shown in the cycle of the read. A clear-on-read therefore removes only the source that was reported. For every source that a read or FIFO condition clears, `clr_o` gives a one-cycle pulse back to the logic that owns the source. Only the channel carrying the shared timer reports the timer code; this is set by a parameter.

Top module: `uart_irq_encoder`

## Requirements
- R1: During reset and in the first cycle after it, with all inputs low, `isr_code_o` is 0, `irq_o` is 0 and `clr_o` is 0.
- R2: Code 1 is reported while `rx_lvl_i` is high (receive FIFO at or above its trigger level), in the same cycle, and is dropped as soon as the level falls.
- R3: A pulse on any bit of `lsr_evt_i` (line status bits 4 down to 1) latches a line-status flag that also reports code 1. Only `lsr_rd_i` clears this flag; a status register read leaves it set.
- R4: A pulse on `rto_evt_i` latches code 2, which clears at the first clock edge with `rx_empty_i` high. If the event and the empty condition come in the same cycle, the event wins.
- R5: Code 3 is latched on a 0-to-1 transition of the selected transmit-empty condition. That condition is `thr_empty_i` when `rs485_auto_i` is 0 and `tsr_empty_i` when it is 1, and it is taken as 0 at reset.
- R6: A clock edge with `isr_rd_i` high clears the code 3 flag only if `isr_code_o` was 3 in that cycle.
- R7: Code 4 is reported while a handshake delta flag (from `hs_evt_i`) or a flow-control/special-character flag (from `flow_evt_i` or `spchar_evt_i`) is set. `msr_rd_i` clears only the handshake flag. A status register read made while code 4 is shown clears only the flow/special flag.
- R8: A pulse on `tmr_evt_i` latches code 7 when `CH0_TIMER` is 1, and `tmr_rd_i` clears it. With `CH0_TIMER` 0, code 7 never appears.
- R9: When several sources are pending, the lowest code wins (1 over 2 over 3 over 4 over 7). Codes 5 and 6 never appear.
- R10: The bits of `src_en_i` map to codes as follows: bit 0 to code 1, bit 1 to code 2, bit 2 to code 3, bit 3 to code 4, bit 4 to code 7. A disabled source is not reported but stays latched. `irq_o` is high exactly when the code is nonzero.
- R11: `clr_o` bit k-1 belongs to code k and pulses, combinationally with the read strobe or empty condition, in the cycle that a set flag of that code is cleared. Bits 4 and 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 5 | Per-source report enables (see R10) |
| rs485_auto_i | input | 1 | Selects shift-register-empty as the transmit condition |
| rx_lvl_i | input | 1 | Receive FIFO at or above trigger level |
| lsr_evt_i | input | LS_W | Line status error events |
| rto_evt_i | input | 1 | Receive data time-out event |
| rx_empty_i | input | 1 | Receive FIFO empty |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| hs_evt_i | input | HS_W | Handshake line delta events |
| flow_evt_i | input | 1 | Xon/Xoff received event |
| spchar_evt_i | input | 1 | Special character detected event |
| tmr_evt_i | input | 1 | Timer time-out event |
| isr_rd_i | input | 1 | Interrupt status register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| tmr_rd_i | input | 1 | Timer control register read strobe |
| isr_code_o | output | 3 | Highest-priority pending source code |
| irq_o | output | 1 | Interrupt request |
| clr_o | output | 7 | Per-code clear pulses |

## Verification
Two things can land in the same cycle: a status register read and a change in which source has the highest priority. The bench makes them coincide by reading the status register while code 2 hides a pending code 3, and also while both a handshake delta and a flow flag are behind code 4. It then checks that only the reported source is cleared, so code 3 survives the read and the handshake delta survives it too. A receive time-out event arriving together with the FIFO-empty condition is used the same way, to show that the set wins over the clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int CODE_W = 3;
  localparam int NCODE  = 7;
  localparam int EN_W   = 5;

  localparam logic [CODE_W-1:0] C_NONE = 3'd0;
  localparam logic [CODE_W-1:0] C_RX   = 3'd1;
  localparam logic [CODE_W-1:0] C_RTO  = 3'd2;
  localparam logic [CODE_W-1:0] C_TX   = 3'd3;
  localparam logic [CODE_W-1:0] C_MDM  = 3'd4;
  localparam logic [CODE_W-1:0] C_TMR  = 3'd7;

  // src_en_i bit positions
  localparam int EN_RX  = 0;
  localparam int EN_RTO = 1;
  localparam int EN_TX  = 2;
  localparam int EN_MDM = 3;
  localparam int EN_TMR = 4;
endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear: an event in the clear cycle is a new event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] code_o,
  output logic         any_o
);
  // bit k is code k+1; lowest code wins
  always_comb begin
    code_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) code_o = W'(k + 1);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
  import uart_irq_pkg::*;
#(
  parameter bit CH0_TIMER = 1'b1,
  parameter int LS_W      = 4,
  parameter int HS_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EN_W-1:0]   src_en_i,
  input  logic              rs485_auto_i,
  input  logic              rx_lvl_i,
  input  logic [LS_W-1:0]   lsr_evt_i,
  input  logic              rto_evt_i,
  input  logic              rx_empty_i,
  input  logic              thr_empty_i,
  input  logic              tsr_empty_i,
  input  logic [HS_W-1:0]   hs_evt_i,
  input  logic              flow_evt_i,
  input  logic              spchar_evt_i,
  input  logic              tmr_evt_i,
  input  logic              isr_rd_i,
  input  logic              lsr_rd_i,
  input  logic              msr_rd_i,
  input  logic              tmr_rd_i,
  output logic [CODE_W-1:0] isr_code_o,
  output logic              irq_o,
  output logic [NCODE-1:0]  clr_o
);

  logic lsr_q, rto_q, tx_q, hs_q, flow_q, tmr_q;
  logic tx_sel, tx_prev_q, tx_rise;
  logic tx_clr, flow_clr;
  logic [NCODE-1:0] pend;
  logic [CODE_W-1:0] code;
  logic any;

  // transmit-empty edge detect on the mode-selected condition
  assign tx_sel = rs485_auto_i ? tsr_empty_i : thr_empty_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_prev_q <= 1'b0;
    else         tx_prev_q <= tx_sel;
  end
  assign tx_rise = tx_sel & ~tx_prev_q;

  // clear-on-status-read acts on the code shown in the read cycle
  assign tx_clr   = isr_rd_i && (code == C_TX);
  assign flow_clr = isr_rd_i && (code == C_MDM);

  irq_flag u_lsr (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (|lsr_evt_i), .clr_i(lsr_rd_i), .q_o(lsr_q)
  );

  irq_flag u_rto (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (rto_evt_i), .clr_i(rx_empty_i), .q_o(rto_q)
  );

  irq_flag u_tx (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (tx_rise), .clr_i(tx_clr), .q_o(tx_q)
  );

  irq_flag u_hs (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (|hs_evt_i), .clr_i(msr_rd_i), .q_o(hs_q)
  );

  irq_flag u_flow (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (flow_evt_i | spchar_evt_i), .clr_i(flow_clr), .q_o(flow_q)
  );

  generate
    if (CH0_TIMER) begin : g_tmr
      irq_flag u_tmr (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .set_i (tmr_evt_i), .clr_i(tmr_rd_i), .q_o(tmr_q)
      );
    end else begin : g_no_tmr
      logic unused_tmr;
      assign unused_tmr = tmr_evt_i ^ tmr_rd_i;
      assign tmr_q = 1'b0;
    end
  endgenerate

  always_comb begin
    pend    = '0;
    pend[0] = src_en_i[EN_RX]  & (rx_lvl_i | lsr_q);
    pend[1] = src_en_i[EN_RTO] & rto_q;
    pend[2] = src_en_i[EN_TX]  & tx_q;
    pend[3] = src_en_i[EN_MDM] & (hs_q | flow_q);
    pend[6] = src_en_i[EN_TMR] & tmr_q;
  end

  irq_prio_enc #(.N(NCODE), .W(CODE_W)) u_enc (
    .pend_i (pend),
    .code_o (code),
    .any_o  (any)
  );

  assign isr_code_o = code;
  assign irq_o      = any;

  always_comb begin
    clr_o    = '0;
    clr_o[0] = lsr_rd_i & lsr_q;
    clr_o[1] = rx_empty_i & rto_q & ~rto_evt_i;
    clr_o[2] = tx_clr & ~tx_rise;
    clr_o[3] = (msr_rd_i & hs_q & ~(|hs_evt_i))
             | (flow_clr & flow_q & ~(flow_evt_i | spchar_evt_i));
    clr_o[6] = tmr_rd_i & tmr_q & ~tmr_evt_i;
  end

endmodule

// File: rtl/uart_irq_encoder_chk.sv
module uart_irq_encoder_chk #(
  parameter bit CH0_TIMER = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] src_en_i,
  input logic       rs485_auto_i,
  input logic       thr_empty_i,
  input logic       tsr_empty_i,
  input logic       rto_evt_i,
  input logic       rx_empty_i,
  input logic       tmr_evt_i,
  input logic       isr_rd_i,
  input logic       tmr_rd_i,
  input logic [2:0] isr_code_o,
  input logic       irq_o
);
  logic sel;
  assign sel = rs485_auto_i ? tsr_empty_i : thr_empty_i;

  a_r10_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> isr_code_o == 3'd0);

  a_r9_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_code_o != 3'd5 && isr_code_o != 3'd6);

  a_r10_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_en_i == 5'd0 |-> !irq_o);

  a_r4_rto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i && !rto_evt_i |=> isr_code_o != 3'd2);

  a_r6_tx_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_rd_i && isr_code_o == 3'd3 && sel && $past(sel) |=> isr_code_o != 3'd3);

  a_r8_timer_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_rd_i && !tmr_evt_i |=> isr_code_o != 3'd7);

  generate
    if (!CH0_TIMER) begin : g_nt
      a_r8_no_timer_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        isr_code_o != 3'd7);
    end
  endgenerate
endmodule

bind uart_irq_encoder uart_irq_encoder_chk #(.CH0_TIMER(CH0_TIMER)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_en_i     (src_en_i),
  .rs485_auto_i (rs485_auto_i),
  .thr_empty_i  (thr_empty_i),
  .tsr_empty_i  (tsr_empty_i),
  .rto_evt_i    (rto_evt_i),
  .rx_empty_i   (rx_empty_i),
  .tmr_evt_i    (tmr_evt_i),
  .isr_rd_i     (isr_rd_i),
  .tmr_rd_i     (tmr_rd_i),
  .isr_code_o   (isr_code_o),
  .irq_o        (irq_o)
);

// File: tb/uart_irq_encoder_tb.sv
module uart_irq_encoder_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] src_en_i = 5'h1f;
  logic rs485_auto_i = 0, rx_lvl_i = 0, rto_evt_i = 0, rx_empty_i = 0;
  logic thr_empty_i = 0, tsr_empty_i = 0, flow_evt_i = 0, spchar_evt_i = 0;
  logic tmr_evt_i = 0, isr_rd_i = 0, lsr_rd_i = 0, msr_rd_i = 0, tmr_rd_i = 0;
  logic [3:0] lsr_evt_i = '0;
  logic [1:0] hs_evt_i = '0;
  logic [2:0] code, code_nt;
  logic irq, irq_nt;
  logic [6:0] clr, clr_nt;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  uart_irq_encoder u_dut (
    .clk_i, .rst_ni, .src_en_i, .rs485_auto_i, .rx_lvl_i, .lsr_evt_i,
    .rto_evt_i, .rx_empty_i, .thr_empty_i, .tsr_empty_i, .hs_evt_i,
    .flow_evt_i, .spchar_evt_i, .tmr_evt_i, .isr_rd_i, .lsr_rd_i,
    .msr_rd_i, .tmr_rd_i, .isr_code_o(code), .irq_o(irq), .clr_o(clr)
  );

  uart_irq_encoder #(.CH0_TIMER(1'b0)) u_dut_nt (
    .clk_i, .rst_ni, .src_en_i, .rs485_auto_i, .rx_lvl_i, .lsr_evt_i,
    .rto_evt_i, .rx_empty_i, .thr_empty_i, .tsr_empty_i, .hs_evt_i,
    .flow_evt_i, .spchar_evt_i, .tmr_evt_i, .isr_rd_i, .lsr_rd_i,
    .msr_rd_i, .tmr_rd_i, .isr_code_o(code_nt), .irq_o(irq_nt), .clr_o(clr_nt)
  );

  // [14:3] rx_lvl lsr rto empty thr hs flow tmr isr_rd lsr_rd msr_rd tmr_rd, [2:0] code
  localparam int NV = 27;
  localparam logic [14:0] TBL [NV] = '{
    {12'b000000000000, 3'd0},  // R1 idle
    {12'b100000000000, 3'd1},  // R2 level
    {12'b000000000000, 3'd0},  // R2 level drop
    {12'b001000000000, 3'd2},  // R4 set
    {12'b000000000000, 3'd2},  // R4 sticky
    {12'b000100000000, 3'd0},  // R4 empty clears
    {12'b000010000000, 3'd3},  // R5 rise
    {12'b000010000000, 3'd3},
    {12'b001010000000, 3'd2},  // R9 2 over 3
    {12'b000010001000, 3'd2},  // R6 read shows 2, tx kept
    {12'b000110000000, 3'd3},  // R4 clear exposes 3
    {12'b000010001000, 3'd0},  // R6 read shows 3, cleared
    {12'b000010000000, 3'd0},  // R5 no new rise
    {12'b000000000000, 3'd0},
    {12'b000001100000, 3'd4},  // R7 hs + flow
    {12'b000000001000, 3'd4},  // R7 isr read clears flow only
    {12'b000000000010, 3'd0},  // R7 msr read clears hs
    {12'b000000100000, 3'd4},  // R7 flow
    {12'b000000000010, 3'd4},  // R7 msr read keeps flow
    {12'b000000001000, 3'd0},  // R7 isr read clears flow
    {12'b000000010000, 3'd7},  // R8 timer
    {12'b010000000000, 3'd1},  // R9 1 over 7, R3 set
    {12'b000000001000, 3'd1},  // R3 isr read keeps lsr flag
    {12'b000000000100, 3'd7},  // R3 lsr read clears
    {12'b000000000001, 3'd0},  // R8 timer read clears
    {12'b001100000000, 3'd2},  // R4 set wins
    {12'b000100000000, 3'd0}   // R4 clear
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [11:0] v);
    rx_lvl_i    = v[11];
    lsr_evt_i   = {3'b0, v[10]};
    rto_evt_i   = v[9];
    rx_empty_i  = v[8];
    thr_empty_i = v[7];
    hs_evt_i    = {1'b0, v[6]};
    flow_evt_i  = v[5];
    tmr_evt_i   = v[4];
    isr_rd_i    = v[3];
    lsr_rd_i    = v[2];
    msr_rd_i    = v[1];
    tmr_rd_i    = v[0];
  endtask

  // called at a negedge: apply, one edge, back at the next negedge
  task automatic step(logic [11:0] v);
    drive(v);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #5;
    check("R1 code in reset", int'(code), 0);
    check("R1 irq in reset", int'(irq), 0);
    check("R1 clr in reset", int'(clr), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 code after reset", int'(code), 0);
    check("R1 irq after reset", int'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][14:3]);
      check($sformatf("R9 vec%0d code", i), int'(code), int'(TBL[i][2:0]));
      check($sformatf("R10 vec%0d irq", i), int'(irq), int'(TBL[i][2:0] != 0));
    end
    step('0);

    // R11 line status clear pulse
    step(12'b010000000000);
    drive(12'b000000000100);
    #1 check("R11 clr lsr", int'(clr), 7'b0000001);
    @(posedge clk_i); @(negedge clk_i);
    check("R3 cleared", int'(code), 0);
    step('0);

    // R11 transmit clear pulse on status read
    step(12'b000010000000);
    check("R5 tx set", int'(code), 3);
    drive(12'b000010001000);
    #1 check("R11 clr tx", int'(clr), 7'b0000100);
    @(posedge clk_i); @(negedge clk_i);
    check("R6 tx cleared", int'(code), 0);
    step('0);

    // R11 timer clear pulse; R8 channel without timer
    step(12'b000000010000);
    check("R8 ch0 timer", int'(code), 7);
    check("R8 other channel code", int'(code_nt), 0);
    check("R8 other channel irq", int'(irq_nt), 0);
    drive(12'b000000000001);
    #1 check("R11 clr timer", int'(clr), 7'b1000000);
    check("R11 clr other channel", int'(clr_nt), 0);
    @(posedge clk_i); @(negedge clk_i);
    check("R8 timer cleared", int'(code), 0);
    step('0);

    // R7 special character and second handshake bit
    spchar_evt_i = 1'b1;
    step('0);
    spchar_evt_i = 1'b0;
    check("R7 spchar", int'(code), 4);
    step(12'b000000001000);
    check("R7 spchar cleared by isr read", int'(code), 0);
    hs_evt_i = 2'b10;
    @(posedge clk_i); @(negedge clk_i);
    hs_evt_i = 2'b00;
    check("R7 hs bit1", int'(code), 4);
    drive(12'b000000000010);
    #1 check("R11 clr modem", int'(clr), 7'b0001000);
    @(posedge clk_i); @(negedge clk_i);
    step('0);
    check("R7 hs cleared", int'(code), 0);

    // R10 masking keeps the flag latched
    src_en_i = 5'b00000;
    step(12'b000000010000);
    step('0);
    check("R10 masked irq", int'(irq), 0);
    check("R10 masked code", int'(code), 0);
    src_en_i = 5'b10000;
    #1 check("R10 unmasked latched timer", int'(code), 7);
    check("R10 unmasked irq", int'(irq), 1);
    step(12'b000000000001);
    src_en_i = 5'h1f;
    step('0);

    // R5 shift-register mode selects tsr_empty_i
    rs485_auto_i = 1'b1;
    step(12'b000010000000);
    check("R5 thr ignored in 485 mode", int'(code), 0);
    tsr_empty_i = 1'b1;
    step(12'b000010000000);
    check("R5 tsr rise in 485 mode", int'(code), 3);
    step(12'b000010001000);
    check("R6 cleared in 485 mode", int'(code), 0);
    step('0);
    tsr_empty_i = 1'b0;
    step('0);
    rs485_auto_i = 1'b0;
    step('0);
    check("R5 no spurious on mode return", int'(code), 0);

    // R1 reset mid-run
    step(12'b001000000000);
    rst_ni = 1'b0;
    #1 check("R1 async reset code", int'(code), 0);
    check("R1 async reset irq", int'(irq), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step('0);
    check("R1 post reset", int'(code), 0);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      finish_run();
    end
  end
endmodule